// File: doc/BRIEF.md
# Two-State Interrupt Sequencer

This block decides when a processor leaves its normal processing state for its interrupt state, and when it comes back. Four kinds of request feed it: the completion of an I/O channel, an illegal operation code, an arithmetic overflow or divide exception, and a tick of the elapsed timer. Each maskable request waits in a pending store until its enable bit allows it. Requests are only considered at an instruction boundary, and only while the processor is in the processing state. The interrupt state itself cannot be interrupted.

When a request wins, the sequencer saves state into reserved low-memory bytes. It does this through a one-byte write port with a valid/ready handshake. The first write always saves the old condition code. The entry type then decides which further writes follow. Once the last write has been accepted, the block switches to the interrupt state. It also loads a new condition code that tells software what caused the entry. While in the interrupt state it points the processor at the interrupt-state program counter. A return strobe takes it back to the processing state.

Top module: `irq_seq`

## Requirements
- R1: After a synchronous reset the block is in the processing state (`in_p2`=0). `pc_addr` reads 40, `wr_valid` is 0 and `cc_load` is 0.
- R2: Every entry first writes byte 43, with data `{6'b0, cc_in}` and lane mask 8'h03. `cc_in` is the value captured at the accepting boundary.
- R3: An illegal-opcode request (`trap_req` together with `instr_done`) is never masked. Its second write puts `trap_opc` into byte 42 with lane mask 8'hFF. The new condition code is `trap_ilen`, where 00 means a 2-byte, 01 a 4-byte and 11 a 6-byte instruction.
- R4: An I/O entry writes the channel status into byte 46. It then writes byte 47 with the channel number in bits 7:4 and the device number in bits 3:0. The new condition code is 00.
- R5: An overflow or divide-exception entry sets the new condition code to 10. `sys_mask` bit 1 enables overflow and bit 0 enables divide exception, where 1 means allowed. The entry makes only the byte-43 write.
- R6: A timer entry sets the new condition code to 11. It is enabled by `sys_mask` bit 2 and makes only the byte-43 write.
- R7: A request whose enable bit is 0 stays pending. It is taken at a later boundary once its bit is 1. `io_mask` bit n enables channel n.
- R8: The fixed priority is: opcode trap, then overflow, then divide exception, then timer, then I/O. Among enabled I/O channels, the lowest number wins. Each acceptance consumes exactly one request.
- R9: No request is accepted while in the interrupt state or while an entry is in progress. Such requests stay pending.
- R10: A write advances only when `wr_valid` and `wr_ready` are both 1. While it is stalled, address, data and lane mask hold steady.
- R11: `ret_strobe` in the interrupt state returns the block to the processing state on the next cycle, with `pc_addr` back to 40. In the processing state it has no effect.
- R12: Requests start an entry only in a cycle with `instr_done` high. The first write appears in the cycle after that boundary.
- R13: In the cycle after the last write handshake, `in_p2` is 1, `pc_addr` reads 44 and `cc_load` pulses for one cycle with the new condition code on `cc_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_done | input | 1 | Instruction boundary pulse |
| ret_strobe | input | 1 | Return from interrupt state |
| cc_in | input | 2 | Current condition code |
| trap_req | input | 1 | Illegal operation code seen (valid with instr_done) |
| trap_opc | input | 8 | Offending operation code |
| trap_ilen | input | 2 | Instruction length code of the trapping instruction |
| ovf_req | input | 1 | Arithmetic overflow event |
| div_req | input | 1 | Divide exception event |
| tmr_req | input | 1 | Elapsed timer event |
| io_req | input | 1 | I/O channel completion event |
| io_chan | input | CW (3) | Completing channel number |
| io_stat | input | 8 | Device status byte of that channel |
| io_dev | input | 4 | Device number on that channel |
| io_mask | input | NCH (8) | Per-channel enable, 1 allows |
| sys_mask | input | 3 | Enables: bit 2 timer, bit 1 overflow, bit 0 divide |
| wr_valid | output | 1 | Reserved-byte write request |
| wr_ready | input | 1 | Write accepted by memory side |
| wr_addr | output | AW (8) | Reserved byte address |
| wr_data | output | 8 | Write data |
| wr_lane | output | 8 | Bit-lane write mask |
| in_p2 | output | 1 | 1 while in the interrupt state |
| pc_addr | output | AW (8) | Address of the active program counter (40 or 44) |
| cc_out | output | 2 | New condition code |
| cc_load | output | 1 | One-cycle strobe to load cc_out |

## Verification
Two events can collide at one boundary. One is a fresh `instr_done` carrying an opcode trap. The other is a set of maskable requests left pending by earlier masks or by an earlier stay in the interrupt state. The bench builds these collisions on purpose, both in directed cases and in random episodes where masks, pending sets and trap pulses are drawn together. A bench-side priority model predicts the one winner, its exact write list and its condition code. It then checks that the losers are still pending by observing them win at later boundaries. Random `wr_ready` stalls run across every entry, and the bench also retries boundaries while in the interrupt state, to confirm that nothing is accepted there.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_TRAP = 3'd1,
    SRC_OVF  = 3'd2,
    SRC_DIV  = 3'd3,
    SRC_TMR  = 3'd4,
    SRC_IO   = 3'd5
  } src_e;

  localparam int unsigned ADR_PC_PROC = 40;
  localparam int unsigned ADR_OPC     = 42;
  localparam int unsigned ADR_CC      = 43;
  localparam int unsigned ADR_PC_INT  = 44;
  localparam int unsigned ADR_STAT    = 46;
  localparam int unsigned ADR_ID      = 47;

  localparam logic [1:0] CC_IO    = 2'b00;
  localparam logic [1:0] CC_ARITH = 2'b10;
  localparam logic [1:0] CC_TMR   = 2'b11;
endpackage

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int unsigned NCH = 8,
  localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                set_ovf,
  input  logic                set_div,
  input  logic                set_tmr,
  input  logic                set_io,
  input  logic [CW-1:0]       set_chan,
  input  logic [7:0]          set_stat,
  input  logic [3:0]          set_dev,
  input  logic                clr_ovf,
  input  logic                clr_div,
  input  logic                clr_tmr,
  input  logic [NCH-1:0]      clr_io,
  output logic                p_ovf,
  output logic                p_div,
  output logic                p_tmr,
  output logic [NCH-1:0]      p_io,
  output logic [NCH-1:0][7:0] ch_stat,
  output logic [NCH-1:0][3:0] ch_dev
);
  always_ff @(posedge clk) begin
    if (rst) begin
      p_ovf <= 1'b0;
      p_div <= 1'b0;
      p_tmr <= 1'b0;
    end else begin
      p_ovf <= set_ovf | (p_ovf & ~clr_ovf);
      p_div <= set_div | (p_div & ~clr_div);
      p_tmr <= set_tmr | (p_tmr & ~clr_tmr);
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit;
    assign hit = set_io && (set_chan == CW'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        p_io[g]    <= 1'b0;
        ch_stat[g] <= '0;
        ch_dev[g]  <= '0;
      end else begin
        p_io[g] <= hit | (p_io[g] & ~clr_io[g]);
        if (hit) begin
          ch_stat[g] <= set_stat;
          ch_dev[g]  <= set_dev;
        end
      end
    end
  end
endmodule

// File: rtl/irq_arb.sv
module irq_arb #(
  parameter int unsigned NCH = 8,
  localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            trap,
  input  logic            p_ovf,
  input  logic            p_div,
  input  logic            p_tmr,
  input  logic [NCH-1:0]  p_io,
  input  logic [NCH-1:0]  io_mask,
  input  logic [2:0]      sys_mask,
  output irq_pkg::src_e   src,
  output logic [CW-1:0]   chan
);
  import irq_pkg::*;
  logic [NCH-1:0] io_ok;
  logic           io_any;

  assign io_ok  = p_io & io_mask;
  assign io_any = |io_ok;

  always_comb begin
    chan = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (io_ok[i]) chan = CW'(i);
    end
  end

  always_comb begin
    if (trap)                    src = SRC_TRAP;
    else if (p_ovf && sys_mask[1]) src = SRC_OVF;
    else if (p_div && sys_mask[0]) src = SRC_DIV;
    else if (p_tmr && sys_mask[2]) src = SRC_TMR;
    else if (io_any)             src = SRC_IO;
    else                         src = SRC_NONE;
  end
endmodule

// File: rtl/irq_wrseq.sv
module irq_wrseq #(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  irq_pkg::src_e src,
  input  logic [7:0]    opc,
  input  logic [1:0]    ilen,
  input  logic [1:0]    cc_old,
  input  logic [7:0]    stat,
  input  logic [7:0]    id_byte,
  input  logic          wr_ready,
  output logic          busy,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic [7:0]    wr_lane,
  output logic          done,
  output logic [1:0]    cc_new
);
  import irq_pkg::*;
  logic [1:0] step, last;
  src_e       src_q;
  logic [7:0] opc_q, stat_q, id_q;
  logic [1:0] cc_q;

  assign done = busy && wr_ready && (step == last);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      step   <= '0;
      last   <= '0;
      src_q  <= SRC_NONE;
      opc_q  <= '0;
      stat_q <= '0;
      id_q   <= '0;
      cc_q   <= '0;
      cc_new <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      step   <= '0;
      src_q  <= src;
      opc_q  <= opc;
      stat_q <= stat;
      id_q   <= id_byte;
      cc_q   <= cc_old;
      case (src)
        SRC_TRAP: begin last <= 2'd1; cc_new <= ilen;     end
        SRC_IO:   begin last <= 2'd2; cc_new <= CC_IO;    end
        SRC_TMR:  begin last <= 2'd0; cc_new <= CC_TMR;   end
        default:  begin last <= 2'd0; cc_new <= CC_ARITH; end
      endcase
    end else if (busy && wr_ready) begin
      if (step == last) busy <= 1'b0;
      else              step <= step + 2'd1;
    end
  end

  always_comb begin
    wr_addr = AW'(ADR_CC);
    wr_data = {6'b0, cc_q};
    wr_lane = 8'h03;
    if (step == 2'd1) begin
      wr_lane = 8'hFF;
      if (src_q == SRC_TRAP) begin
        wr_addr = AW'(ADR_OPC);
        wr_data = opc_q;
      end else begin
        wr_addr = AW'(ADR_STAT);
        wr_data = stat_q;
      end
    end else if (step == 2'd2) begin
      wr_lane = 8'hFF;
      wr_addr = AW'(ADR_ID);
      wr_data = id_q;
    end
  end
endmodule

// File: rtl/irq_seq.sv
module irq_seq #(
  parameter int unsigned NCH = 8,
  parameter int unsigned AW  = 8,
  localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           instr_done,
  input  logic           ret_strobe,
  input  logic [1:0]     cc_in,
  input  logic           trap_req,
  input  logic [7:0]     trap_opc,
  input  logic [1:0]     trap_ilen,
  input  logic           ovf_req,
  input  logic           div_req,
  input  logic           tmr_req,
  input  logic           io_req,
  input  logic [CW-1:0]  io_chan,
  input  logic [7:0]     io_stat,
  input  logic [3:0]     io_dev,
  input  logic [NCH-1:0] io_mask,
  input  logic [2:0]     sys_mask,
  output logic           wr_valid,
  input  logic           wr_ready,
  output logic [AW-1:0]  wr_addr,
  output logic [7:0]     wr_data,
  output logic [7:0]     wr_lane,
  output logic           in_p2,
  output logic [AW-1:0]  pc_addr,
  output logic [1:0]     cc_out,
  output logic           cc_load
);
  import irq_pkg::*;

  logic                p_ovf, p_div, p_tmr;
  logic [NCH-1:0]      p_io;
  logic [NCH-1:0][7:0] ch_stat;
  logic [NCH-1:0][3:0] ch_dev;
  src_e                src;
  logic [CW-1:0]       win_ch;
  logic                busy, seq_done, accept;
  logic [1:0]          cc_new;
  logic [NCH-1:0]      clr_io;
  logic [7:0]          id_byte;

  assign accept  = instr_done && !in_p2 && !busy && (src != SRC_NONE);
  assign clr_io  = (accept && src == SRC_IO) ? (NCH'(1) << win_ch) : '0;
  assign id_byte = {4'(win_ch), ch_dev[win_ch]};

  irq_pend #(.NCH(NCH)) u_pend (
    .clk(clk), .rst(rst),
    .set_ovf(ovf_req), .set_div(div_req), .set_tmr(tmr_req),
    .set_io(io_req), .set_chan(io_chan), .set_stat(io_stat), .set_dev(io_dev),
    .clr_ovf(accept && src == SRC_OVF),
    .clr_div(accept && src == SRC_DIV),
    .clr_tmr(accept && src == SRC_TMR),
    .clr_io(clr_io),
    .p_ovf(p_ovf), .p_div(p_div), .p_tmr(p_tmr), .p_io(p_io),
    .ch_stat(ch_stat), .ch_dev(ch_dev)
  );

  irq_arb #(.NCH(NCH)) u_arb (
    .trap(trap_req && instr_done),
    .p_ovf(p_ovf), .p_div(p_div), .p_tmr(p_tmr), .p_io(p_io),
    .io_mask(io_mask), .sys_mask(sys_mask),
    .src(src), .chan(win_ch)
  );

  irq_wrseq #(.AW(AW)) u_seq (
    .clk(clk), .rst(rst), .start(accept), .src(src),
    .opc(trap_opc), .ilen(trap_ilen), .cc_old(cc_in),
    .stat(ch_stat[win_ch]), .id_byte(id_byte),
    .wr_ready(wr_ready), .busy(busy),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_lane(wr_lane),
    .done(seq_done), .cc_new(cc_new)
  );

  assign wr_valid = busy;
  assign pc_addr  = in_p2 ? AW'(ADR_PC_INT) : AW'(ADR_PC_PROC);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_p2   <= 1'b0;
      cc_out  <= '0;
      cc_load <= 1'b0;
    end else begin
      cc_load <= 1'b0;
      if (seq_done) begin
        in_p2   <= 1'b1;
        cc_out  <= cc_new;
        cc_load <= 1'b1;
      end else if (in_p2 && ret_strobe) begin
        in_p2 <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          instr_done,
  input logic          ret_strobe,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    wr_data,
  input logic [7:0]    wr_lane,
  input logic          in_p2,
  input logic [AW-1:0] pc_addr,
  input logic          cc_load
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> !wr_valid && !in_p2 && !cc_load);
  // R2
  first_write_cc_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_valid) |-> (wr_addr == AW'(43)) && (wr_lane == 8'h03));
  // R9
  no_write_in_p2_chk: assert property (@(posedge clk) disable iff (rst) in_p2 |-> !wr_valid);
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_lane));
  // R11
  return_chk: assert property (@(posedge clk) disable iff (rst) in_p2 && ret_strobe |=> !in_p2);
  // R12
  boundary_start_chk: assert property (@(posedge clk) disable iff (rst) $rose(wr_valid) |-> $past(instr_done));
  // R13
  load_in_p2_chk: assert property (@(posedge clk) disable iff (rst)
    cc_load |-> in_p2 && (pc_addr == AW'(44)) && $rose(in_p2));
endmodule

bind irq_seq irq_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .instr_done(instr_done), .ret_strobe(ret_strobe),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
  .wr_lane(wr_lane), .in_p2(in_p2), .pc_addr(pc_addr), .cc_load(cc_load)
);

// File: tb/test_irq_seq.sv
module test_irq_seq;
  localparam int NCH = 8;
  localparam int AW  = 8;
  localparam int CW  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic instr_done = 0, ret_strobe = 0, trap_req = 0;
  logic [1:0] cc_in = 0, trap_ilen = 0;
  logic [7:0] trap_opc = 0, io_stat = 0;
  logic ovf_req = 0, div_req = 0, tmr_req = 0, io_req = 0;
  logic [CW-1:0] io_chan = 0;
  logic [3:0] io_dev = 0;
  logic [NCH-1:0] io_mask = 0;
  logic [2:0] sys_mask = 0;
  logic wr_valid, wr_ready = 0;
  logic [AW-1:0] wr_addr, pc_addr;
  logic [7:0] wr_data, wr_lane;
  logic in_p2, cc_load;
  logic [1:0] cc_out;

  always #4 clk = ~clk;

  irq_seq #(.NCH(NCH), .AW(AW)) i_irq_seq (.*);

  int checks = 0, failures = 0;
  bit m_ovf, m_div, m_tmr, m_p2;
  bit [NCH-1:0] m_io;
  logic [7:0] m_stat [NCH];
  logic [3:0] m_dev [NCH];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  // pulse request inputs for one cycle and track the pending model
  task automatic raise(input bit o, input bit d, input bit t, input bit io,
                       input int ch, input logic [7:0] st, input logic [3:0] dv);
    ovf_req = o; div_req = d; tmr_req = t; io_req = io;
    io_chan = CW'(ch); io_stat = st; io_dev = dv;
    if (o) m_ovf = 1; if (d) m_div = 1; if (t) m_tmr = 1;
    if (io) begin m_io[ch] = 1; m_stat[ch] = st; m_dev[ch] = dv; end
    @(negedge clk);
    ovf_req = 0; div_req = 0; tmr_req = 0; io_req = 0;
  endtask

  function automatic int pick(input bit trap, output int ch);
    ch = 0;
    if (trap) return 1;
    if (m_ovf && sys_mask[1]) return 2;
    if (m_div && sys_mask[0]) return 3;
    if (m_tmr && sys_mask[2]) return 4;
    for (int i = 0; i < NCH; i++) if (m_io[i] && io_mask[i]) begin ch = i; return 5; end
    return 0;
  endfunction

  task automatic boundary(input bit trap, input logic [7:0] opc, input logic [1:0] il,
                          input logic [1:0] cc, input string tag);
    int src, ch, n, k, guard;
    logic [7:0] ea [3], ed [3], el [3];
    logic [1:0] ecc;
    src = m_p2 ? 0 : pick(trap, ch);
    instr_done = 1; trap_req = trap; trap_opc = opc; trap_ilen = il; cc_in = cc;
    @(negedge clk);
    instr_done = 0; trap_req = 0;
    if (src == 0) begin
      chk(!wr_valid, {tag, " no entry"}, wr_valid, 0);
      @(negedge clk);
      chk(!wr_valid, {tag, " no entry later"}, wr_valid, 0);
      return;
    end
    ea[0] = 43; ed[0] = {6'b0, cc}; el[0] = 8'h03; n = 1;
    case (src)
      1: begin ea[1] = 42; ed[1] = opc; el[1] = 8'hFF; n = 2; ecc = il; end
      2: begin ecc = 2'b10; m_ovf = 0; end
      3: begin ecc = 2'b10; m_div = 0; end
      4: begin ecc = 2'b11; m_tmr = 0; end
      default: begin
        ea[1] = 46; ed[1] = m_stat[ch]; el[1] = 8'hFF;
        ea[2] = 47; ed[2] = {4'(ch), m_dev[ch]}; el[2] = 8'hFF;
        n = 3; ecc = 2'b00; m_io[ch] = 0;
      end
    endcase
    k = 0; guard = 0;
    while (k < n && guard < 200) begin
      guard++;
      chk(wr_valid === 1'b1, {tag, " wr_valid R10"}, wr_valid, 1);
      chk(wr_addr == ea[k] && wr_data == ed[k] && wr_lane == el[k],
          {tag, " write R2/R3/R4"}, {wr_addr, wr_data, wr_lane}, {ea[k], ed[k], el[k]});
      chk(!in_p2, {tag, " not yet P2 R13"}, in_p2, 0);
      wr_ready = ($urandom % 3) != 0;
      @(posedge clk);
      if (wr_ready) k++;
      @(negedge clk);
    end
    wr_ready = 0;
    m_p2 = 1;
    chk(in_p2 && cc_load && pc_addr == 44, {tag, " entry done R13"}, {in_p2, cc_load, pc_addr}, {1'b1, 1'b1, 8'd44});
    chk(cc_out == ecc, {tag, " new cc R3/R4/R5/R6"}, cc_out, ecc);
    chk(!wr_valid, {tag, " writes ended"}, wr_valid, 0);
    @(negedge clk);
    chk(!cc_load, {tag, " cc_load one cycle R13"}, cc_load, 0);
  endtask

  task automatic do_ret();
    ret_strobe = 1;
    @(negedge clk);
    ret_strobe = 0;
    m_p2 = 0;
    chk(!in_p2 && pc_addr == 40, "R11 return", {in_p2, pc_addr}, {1'b0, 8'd40});
  endtask

  initial begin
    void'($urandom(32'h5EED));
    m_ovf = 0; m_div = 0; m_tmr = 0; m_p2 = 0; m_io = '0;
    for (int i = 0; i < NCH; i++) begin m_stat[i] = 0; m_dev[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!in_p2 && pc_addr == 40 && !wr_valid && !cc_load, "R1 reset state",
        {in_p2, pc_addr, wr_valid, cc_load}, {1'b0, 8'd40, 1'b0, 1'b0});

    // R11: return in processing state has no effect
    ret_strobe = 1; @(negedge clk); ret_strobe = 0;
    chk(!in_p2 && pc_addr == 40, "R11 ret ignored in P1", in_p2, 0);

    // R7 masked requests stay pending; R12 no start without boundary
    raise(1, 0, 1, 1, 5, 8'hA5, 4'h9);
    repeat (4) @(negedge clk);
    chk(!wr_valid, "R12 pending without boundary", wr_valid, 0);
    boundary(0, 0, 0, 2'b01, "R7 all masked");
    sys_mask = 3'b100;
    boundary(0, 0, 0, 2'b01, "R6 timer");
    do_ret();
    sys_mask = 3'b111; io_mask = '1;
    raise(0, 0, 0, 1, 3, 8'h3C, 4'h2);
    boundary(0, 0, 0, 2'b10, "R8 overflow first");
    do_ret();
    boundary(0, 0, 0, 2'b11, "R4 lowest channel 3");
    // R9 blocked in P2, request kept
    raise(0, 1, 0, 0, 0, 0, 0);
    boundary(0, 0, 0, 2'b00, "R9 blocked in P2");
    boundary(1, 8'h77, 2'b11, 2'b00, "R9 trap blocked in P2");
    do_ret();
    boundary(0, 0, 0, 2'b10, "R5 divide after return");
    do_ret();
    // R3 trap beats pending I/O and ignores masks
    sys_mask = 3'b000; io_mask = '0;
    boundary(1, 8'hFA, 2'b01, 2'b11, "R3 trap unmasked");
    do_ret();
    io_mask = 8'h20;
    boundary(0, 0, 0, 2'b00, "R7 channel 5 released");
    do_ret();

    // random episodes
    for (int e = 0; e < 80; e++) begin
      io_mask = NCH'($urandom);
      sys_mask = 3'($urandom);
      raise($urandom % 4 == 0, $urandom % 4 == 0, $urandom % 4 == 0, $urandom % 2 == 0,
            $urandom % NCH, 8'($urandom), 4'($urandom));
      if ($urandom % 3 == 0)
        raise(0, 0, 0, 1, $urandom % NCH, 8'($urandom), 4'($urandom));
      boundary($urandom % 5 == 0, 8'($urandom), ($urandom % 2) ? 2'b11 : 2'b01,
               2'($urandom), "R8 random");
      if (m_p2) begin
        if ($urandom % 2) boundary($urandom % 2 == 0, 8'h11, 2'b00, 2'b00, "R9 random in P2");
        do_ret();
      end
    end
    finish_run();
  end
endmodule